// File: doc/BRIEF.md
# Variable-Page TLB Lookup with Zones

This block searches a fully associative table of address translations in one cycle. A request gives a virtual address, an access kind (read, write or fetch), a privilege flag and the current process number. Every valid entry is compared against these in parallel. The first entry that qualifies, counted from index zero, decides the outcome. The outcome is a hit with a physical address, a protection fault, or a miss. Page size, entry index and outcome code are registered one clock after the request.

Each entry can have its own page size, from 1 KB to 16 MB. The address compare and the split between page number and page offset follow that size. Each entry also names a protection zone. A 32-bit zone protection word, given as an input, can do three things to an entry's own rights. It can hide the entry from user accesses. It can widen its rights for privileged code. It can widen its rights for every access. The table contents come in as flat input vectors. Loading and invalidating entries is done by the surrounding logic.

Top module: `tlb_zone_lookup`

## Requirements
- R1: Each cycle with `req_i` high gives `vld_o` high in the next cycle and in no other. Each result is held until the next request. Outcome codes on `res_o` are 0 = miss, 1 = hit and 2 = protection fault. Code 3 never appears.
- R2: A tag word holds the valid flag at bit 6, a page-size code at bits [9:7] and the page number at bits [31:10]. Size codes 0..7 select 1 KB, 4 KB, 16 KB, 64 KB, 256 KB, 1 MB, 4 MB and 16 MB. An entry's address matches when the virtual address and the tag agree on every bit above the page offset of that size.
- R3: An owner number of 0 makes an entry global, so it matches any process. Any other owner number must equal `pid_i`.
- R4: When several entries qualify, the one with the lowest index decides the result.
- R5: A data word holds the zone number at bits [7:4]. Zone z reads protection bits [31-2z:30-2z] of `zpr_i`. Code 00 makes a user access (`priv_i` = 0) pass over the entry, and the search goes on to higher entries. A privileged access to a code 00 entry uses the entry's own rights.
- R6: Zone code 10 gives write and execute rights to privileged accesses. User accesses keep the entry's own rights.
- R7: Zone code 11 gives write and execute rights to every access. Code 01 leaves the entry's own rights unchanged.
- R8: A zone number above `NUM_ZONES` acts as code 01. Every zone acts as code 01 when `ZONE_EN` is 0.
- R9: Reads are always allowed on a deciding entry. A write (`acc_i` = 1) to an entry without write right, or a fetch (`acc_i` = 2) from an entry without execute right, ends the search with a fault. Higher entries are not considered. On a fault, `idx_o` and `size_o` describe the faulting entry and `paddr_o` is 0.
- R10: A data word holds the execute right at bit 9, the write right at bit 8 and the real page number at bits [31:10]. On a hit, `paddr_o` takes the real page number bits above the page offset and the virtual address bits within it. `idx_o` and `size_o` give the entry index and its size code.
- R11: On a miss, `paddr_o`, `idx_o` and `size_o` are all 0.
- R12: After reset, `vld_o` is 0 and `res_o` reads as a miss.

Access code 3 is treated as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Lookup request |
| vaddr_i | input | 32 | Virtual address |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| priv_i | input | 1 | 1 = privileged access, 0 = user access |
| pid_i | input | 8 | Current process number |
| zpr_i | input | 32 | Zone protection word |
| tag_i | input | NUM_ENT*32 | Tag words, entry i at bits [32i+31:32i] |
| data_i | input | NUM_ENT*32 | Data words, same packing |
| owner_i | input | NUM_ENT*8 | Owner numbers, entry i at bits [8i+7:8i] |
| vld_o | output | 1 | Result valid, one cycle after request |
| res_o | output | 2 | Outcome code |
| paddr_o | output | 32 | Physical address on a hit |
| size_o | output | 3 | Page-size code of the deciding entry |
| idx_o | output | $clog2(NUM_ENT) | Index of the deciding entry |

## Verification
Zone handling and priority selection both act in the same cycle. A zone code 00 on a lower-index entry must move the decision to a higher-index entry, and only for user accesses. To provoke this, two entries are given the same page, the lower one set to a denied zone. The same address is then looked up in user and in privileged mode, and `idx_o` must move between the two entries. A second overlap places an entry without rights below an entry with full rights. The fault must come from the lower entry, which shows that a permission failure ends the search and does not fall through.

// File: rtl/tlb_zone_pkg.sv
package tlb_zone_pkg;
  localparam int WORD_W  = 32;
  localparam int OWNER_W = 8;
  localparam int SIZE_W  = 3;
  localparam int ZSEL_W  = 4;
  localparam int MIN_OFF = 10;

  localparam int TAG_VLD_BIT = 6;
  localparam int TAG_SZ_LSB  = 7;
  localparam int DAT_EX_BIT  = 9;
  localparam int DAT_WR_BIT  = 8;
  localparam int DAT_Z_LSB   = 4;

  typedef enum logic [1:0] {
    RES_MISS  = 2'd0,
    RES_HIT   = 2'd1,
    RES_FAULT = 2'd2
  } res_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    ZN_DENY_USER = 2'b00,
    ZN_ENTRY     = 2'b01,
    ZN_PRIV_FULL = 2'b10,
    ZN_ALL_FULL  = 2'b11
  } zone_e;

  // size code c -> page of 2^(10+2c) bytes; mask keeps page-number bits
  function automatic logic [WORD_W-1:0] page_mask(input logic [SIZE_W-1:0] c);
    return {WORD_W{1'b1}} << (5'(MIN_OFF) + {1'b0, c, 1'b0});
  endfunction
endpackage

// File: rtl/tlb_zone_sel.sv
module tlb_zone_sel
  import tlb_zone_pkg::*;
#(
  parameter bit ZONE_EN   = 1'b1,
  parameter int NUM_ZONES = 8
) (
  input  logic [ZSEL_W-1:0] zsel_i,
  input  logic [WORD_W-1:0] zpr_i,
  output logic [1:0]        code_o
);
  localparam logic [ZSEL_W:0] ZMAX = (ZSEL_W+1)'(NUM_ZONES);

  logic [4:0] lsb;
  assign lsb = 5'd30 - {zsel_i, 1'b0};

  always_comb begin
    if (!ZONE_EN || ({1'b0, zsel_i} > ZMAX)) code_o = ZN_ENTRY;
    else                                     code_o = zpr_i[lsb +: 2];
  end
endmodule

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp
  import tlb_zone_pkg::*;
#(
  parameter bit ZONE_EN   = 1'b1,
  parameter int NUM_ZONES = 8
) (
  input  logic [WORD_W-1:0]  vaddr_i,
  input  logic [1:0]         acc_i,
  input  logic               priv_i,
  input  logic [OWNER_W-1:0] pid_i,
  input  logic [WORD_W-1:0]  zpr_i,
  input  logic [WORD_W-1:0]  tag_i,
  input  logic [WORD_W-1:0]  data_i,
  input  logic [OWNER_W-1:0] owner_i,
  output logic               sel_o,
  output logic               deny_o,
  output logic [WORD_W-1:0]  pa_o,
  output logic [SIZE_W-1:0]  size_o
);
  logic [WORD_W-1:0] mask;
  logic [1:0]        zcode;
  logic              addr_ok, own_ok, skip, wr_ok, ex_ok;
  logic              unused_bits;

  assign unused_bits = ^{tag_i[TAG_VLD_BIT-1:0], data_i[DAT_Z_LSB-1:0]};

  assign size_o  = tag_i[TAG_SZ_LSB +: SIZE_W];
  assign mask    = page_mask(size_o);
  assign addr_ok = ((vaddr_i ^ tag_i) & mask) == '0;
  assign own_ok  = (owner_i == '0) || (owner_i == pid_i);

  tlb_zone_sel #(.ZONE_EN(ZONE_EN), .NUM_ZONES(NUM_ZONES)) u_zone (
    .zsel_i (data_i[DAT_Z_LSB +: ZSEL_W]),
    .zpr_i  (zpr_i),
    .code_o (zcode)
  );

  assign skip  = (zcode == ZN_DENY_USER) && !priv_i;
  assign sel_o = tag_i[TAG_VLD_BIT] && addr_ok && own_ok && !skip;

  assign wr_ok = data_i[DAT_WR_BIT] || (zcode == ZN_ALL_FULL)
              || ((zcode == ZN_PRIV_FULL) && priv_i);
  assign ex_ok = data_i[DAT_EX_BIT] || (zcode == ZN_ALL_FULL)
              || ((zcode == ZN_PRIV_FULL) && priv_i);

  assign deny_o = ((acc_i == ACC_WRITE) && !wr_ok)
               || ((acc_i == ACC_FETCH) && !ex_ok);

  assign pa_o = (data_i & mask) | (vaddr_i & ~mask);
endmodule

// File: rtl/tlb_first_pick.sv
module tlb_first_pick #(
  parameter  int NUM_ENT = 64,
  localparam int IW      = $clog2(NUM_ENT)
) (
  input  logic [NUM_ENT-1:0] sel_i,
  output logic               any_o,
  output logic [IW-1:0]      idx_o
);
  assign any_o = |sel_i;

  always_comb begin
    idx_o = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (sel_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/tlb_zone_lookup.sv
module tlb_zone_lookup
  import tlb_zone_pkg::*;
#(
  parameter  int NUM_ENT   = 64,
  parameter  bit ZONE_EN   = 1'b1,
  parameter  int NUM_ZONES = 8,
  localparam int IW        = $clog2(NUM_ENT)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic [WORD_W-1:0]          vaddr_i,
  input  logic [1:0]                 acc_i,
  input  logic                       priv_i,
  input  logic [OWNER_W-1:0]         pid_i,
  input  logic [WORD_W-1:0]          zpr_i,
  input  logic [NUM_ENT*WORD_W-1:0]  tag_i,
  input  logic [NUM_ENT*WORD_W-1:0]  data_i,
  input  logic [NUM_ENT*OWNER_W-1:0] owner_i,
  output logic                       vld_o,
  output logic [1:0]                 res_o,
  output logic [WORD_W-1:0]          paddr_o,
  output logic [SIZE_W-1:0]          size_o,
  output logic [IW-1:0]              idx_o
);
  logic [NUM_ENT-1:0] sel_w, deny_w;
  logic [WORD_W-1:0]  pa_w   [NUM_ENT];
  logic [SIZE_W-1:0]  size_w [NUM_ENT];
  logic               any;
  logic [IW-1:0]      pick;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    tlb_entry_cmp #(.ZONE_EN(ZONE_EN), .NUM_ZONES(NUM_ZONES)) u_cmp (
      .vaddr_i (vaddr_i),
      .acc_i   (acc_i),
      .priv_i  (priv_i),
      .pid_i   (pid_i),
      .zpr_i   (zpr_i),
      .tag_i   (tag_i[g*WORD_W +: WORD_W]),
      .data_i  (data_i[g*WORD_W +: WORD_W]),
      .owner_i (owner_i[g*OWNER_W +: OWNER_W]),
      .sel_o   (sel_w[g]),
      .deny_o  (deny_w[g]),
      .pa_o    (pa_w[g]),
      .size_o  (size_w[g])
    );
  end

  tlb_first_pick #(.NUM_ENT(NUM_ENT)) u_pick (
    .sel_i (sel_w),
    .any_o (any),
    .idx_o (pick)
  );

  logic [1:0]        res_d;
  logic [WORD_W-1:0] pa_d;
  logic [SIZE_W-1:0] size_d;
  logic [IW-1:0]     idx_d;

  always_comb begin
    res_d  = RES_MISS;
    pa_d   = '0;
    size_d = '0;
    idx_d  = '0;
    if (any) begin
      idx_d  = pick;
      size_d = size_w[pick];
      if (deny_w[pick]) res_d = RES_FAULT;
      else begin
        res_d = RES_HIT;
        pa_d  = pa_w[pick];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      res_o   <= RES_MISS;
      paddr_o <= '0;
      size_o  <= '0;
      idx_o   <= '0;
    end else begin
      vld_o <= req_i;
      if (req_i) begin
        res_o   <= res_d;
        paddr_o <= pa_d;
        size_o  <= size_d;
        idx_o   <= idx_d;
      end
    end
  end
endmodule

// File: rtl/tlb_zone_lookup_chk.sv
module tlb_zone_lookup_chk
  import tlb_zone_pkg::*;
#(
  parameter  int NUM_ENT = 64,
  localparam int IW      = $clog2(NUM_ENT)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [WORD_W-1:0] vaddr_i,
  input logic              vld_o,
  input logic [1:0]        res_o,
  input logic [WORD_W-1:0] paddr_o,
  input logic [SIZE_W-1:0] size_o,
  input logic [IW-1:0]     idx_o
);
  // R1
  vld_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> vld_o);
  // R1
  vld_only_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !vld_o);
  // R1
  res_code_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_o != 2'd3);
  // R1
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(res_o) && $stable(paddr_o) && $stable(idx_o)));
  // R10
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && res_o == RES_HIT) |->
      ((paddr_o ^ $past(vaddr_i)) & ~page_mask(size_o)) == '0);
  // R11
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && res_o == RES_MISS) |-> (paddr_o == '0 && idx_o == '0 && size_o == '0));
  // R9
  fault_no_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && res_o == RES_FAULT) |-> paddr_o == '0);
endmodule

bind tlb_zone_lookup tlb_zone_lookup_chk #(.NUM_ENT(NUM_ENT)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .vaddr_i (vaddr_i),
  .vld_o   (vld_o),
  .res_o   (res_o),
  .paddr_o (paddr_o),
  .size_o  (size_o),
  .idx_o   (idx_o)
);

// File: tb/tlb_zone_lookup_tb.sv
`timescale 1ns/1ps
module tlb_zone_lookup_tb;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req = 1'b0;
  logic [31:0] va = '0;
  logic [1:0]  acc = 2'd0;
  logic        priv = 1'b0;
  logic [7:0]  pid = 8'h03;
  logic [31:0] zpr = 32'h5555_5555;
  logic [31:0] tag_a [N];
  logic [31:0] dat_a [N];
  logic [7:0]  own_a [N];
  logic [N*32-1:0] tag_v, dat_v;
  logic [N*8-1:0]  own_v;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      tag_v[i*32 +: 32] = tag_a[i];
      dat_v[i*32 +: 32] = dat_a[i];
      own_v[i*8 +: 8]   = own_a[i];
    end
  end

  logic        vld, vld_nz;
  logic [1:0]  res, res_nz;
  logic [31:0] pa, pa_nz;
  logic [2:0]  sz, sz_nz;
  logic [5:0]  ix, ix_nz;

  tlb_zone_lookup u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .vaddr_i(va), .acc_i(acc),
    .priv_i(priv), .pid_i(pid), .zpr_i(zpr), .tag_i(tag_v), .data_i(dat_v),
    .owner_i(own_v), .vld_o(vld), .res_o(res), .paddr_o(pa), .size_o(sz), .idx_o(ix)
  );

  tlb_zone_lookup #(.ZONE_EN(1'b0)) u_dut_nz (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .vaddr_i(va), .acc_i(acc),
    .priv_i(priv), .pid_i(pid), .zpr_i(zpr), .tag_i(tag_v), .data_i(dat_v),
    .owner_i(own_v), .vld_o(vld_nz), .res_o(res_nz), .paddr_o(pa_nz), .size_o(sz_nz),
    .idx_o(ix_nz)
  );

  int checks = 0;
  int errors = 0;

  localparam logic [1:0] MISS = 2'd0, HIT = 2'd1, FLT = 2'd2;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, FE = 2'd2;

  function automatic logic [31:0] mk_tag(input logic [31:0] a, input logic [2:0] s);
    return {a[31:10], s, 1'b1, 6'b0};
  endfunction

  function automatic logic [31:0] mk_dat(input logic [31:0] r, input logic ex,
                                         input logic w, input logic [3:0] z);
    return {r[31:10], ex, w, z, 4'b0};
  endfunction

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin
      tag_a[i] = '0; dat_a[i] = '0; own_a[i] = '0;
    end
  endtask

  task automatic lookup(input logic [31:0] a, input logic [1:0] k, input logic p);
    @(negedge clk);
    va = a; acc = k; priv = p; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic expect_res(input string rq, input logic [1:0] er, input logic [31:0] ep,
                            input logic [5:0] ei, input logic [2:0] es);
    checks++;
    if (vld !== 1'b1 || res !== er || pa !== ep || ix !== ei || sz !== es) begin
      errors++;
      $display("FAIL %s: vld=%0b res=%0d pa=%h idx=%0d sz=%0d expected vld=1 res=%0d pa=%h idx=%0d sz=%0d",
               rq, vld, res, pa, ix, sz, er, ep, ei, es);
    end
  endtask

  task automatic expect_nz(input string rq, input logic [1:0] er, input logic [5:0] ei);
    checks++;
    if (vld_nz !== 1'b1 || res_nz !== er || ix_nz !== ei) begin
      errors++;
      $display("FAIL %s: res=%0d idx=%0d expected res=%0d idx=%0d", rq, res_nz, ix_nz, er, ei);
    end
  endtask

  task automatic t_reset();
    checks++;
    if (vld !== 1'b0 || res !== MISS) begin
      errors++;
      $display("FAIL R12: vld=%0b res=%0d expected vld=0 res=0", vld, res);
    end
    // R1: no result without request
    @(negedge clk);
    checks++;
    if (vld !== 1'b0) begin
      errors++;
      $display("FAIL R1: vld=%0b expected 0", vld);
    end
  endtask

  task automatic t_miss_empty();
    clear_all();
    lookup(32'h1234_5678, RD, 1'b1);
    expect_res("R11 empty", MISS, 32'h0, 6'd0, 3'd0);
    @(negedge clk);
    checks++;
    if (vld !== 1'b0) begin
      errors++;
      $display("FAIL R1 pulse: vld=%0b expected 0", vld);
    end
  endtask

  task automatic t_sizes();
    clear_all();
    tag_a[5] = mk_tag(32'h0001_2000, 3'd1); dat_a[5] = mk_dat(32'h8000_3000, 1, 1, 4'd0);
    tag_a[6] = mk_tag(32'h0002_0400, 3'd0); dat_a[6] = mk_dat(32'h9000_0800, 1, 1, 4'd0);
    tag_a[9] = mk_tag(32'h0A12_3400, 3'd7); dat_a[9] = mk_dat(32'h4055_5400, 1, 1, 4'd0);
    lookup(32'h0001_2ABC, RD, 1'b0);
    expect_res("R2/R10 4KB", HIT, 32'h8000_3ABC, 6'd5, 3'd1);
    lookup(32'h0001_3000, RD, 1'b0);
    expect_res("R2 4KB out", MISS, 32'h0, 6'd0, 3'd0);
    lookup(32'h0002_07FF, RD, 1'b0);
    expect_res("R2/R10 1KB", HIT, 32'h9000_0BFF, 6'd6, 3'd0);
    lookup(32'h0002_0800, RD, 1'b0);
    expect_res("R2 1KB out", MISS, 32'h0, 6'd0, 3'd0);
    lookup(32'h0AFE_DCBC, RD, 1'b0);
    expect_res("R2/R10 16MB", HIT, 32'h40FE_DCBC, 6'd9, 3'd7);
  endtask

  task automatic t_owner();
    clear_all();
    tag_a[2] = mk_tag(32'h2000_0000, 3'd1); dat_a[2] = mk_dat(32'h3000_0000, 1, 1, 4'd0);
    own_a[2] = 8'h07;
    pid = 8'h07;
    lookup(32'h2000_0010, RD, 1'b0);
    expect_res("R3 owner eq", HIT, 32'h3000_0010, 6'd2, 3'd1);
    pid = 8'h08;
    lookup(32'h2000_0010, RD, 1'b0);
    expect_res("R3 owner ne", MISS, 32'h0, 6'd0, 3'd0);
    tag_a[40] = mk_tag(32'h2000_0000, 3'd1); dat_a[40] = mk_dat(32'h3100_0000, 1, 1, 4'd0);
    lookup(32'h2000_0010, RD, 1'b0);
    expect_res("R3 global", HIT, 32'h3100_0010, 6'd40, 3'd1);
    pid = 8'h03;
  endtask

  task automatic t_prio();
    clear_all();
    tag_a[10] = mk_tag(32'h5000_0000, 3'd1); dat_a[10] = mk_dat(32'hA000_0000, 1, 1, 4'd0);
    tag_a[4]  = mk_tag(32'h5000_0000, 3'd1); dat_a[4]  = mk_dat(32'hB000_0000, 1, 1, 4'd0);
    lookup(32'h5000_0004, RD, 1'b0);
    expect_res("R4 lowest", HIT, 32'hB000_0004, 6'd4, 3'd1);
  endtask

  task automatic t_perm();
    clear_all();
    tag_a[1]  = mk_tag(32'h6000_0000, 3'd1); dat_a[1]  = mk_dat(32'hC000_0000, 0, 0, 4'd0);
    tag_a[20] = mk_tag(32'h6000_0000, 3'd1); dat_a[20] = mk_dat(32'hD000_0000, 1, 1, 4'd0);
    lookup(32'h6000_0044, RD, 1'b1);
    expect_res("R9 read ok", HIT, 32'hC000_0044, 6'd1, 3'd1);
    lookup(32'h6000_0044, WR, 1'b1);
    expect_res("R9 write fault stops", FLT, 32'h0, 6'd1, 3'd1);
    lookup(32'h6000_0044, FE, 1'b1);
    expect_res("R9 fetch fault", FLT, 32'h0, 6'd1, 3'd1);
  endtask

  task automatic t_zone_deny();
    clear_all();
    zpr = 32'h5455_5555;  // zone 3 -> 00
    tag_a[1] = mk_tag(32'h7000_0000, 3'd1); dat_a[1] = mk_dat(32'hE000_0000, 0, 0, 4'd3);
    tag_a[6] = mk_tag(32'h7000_0000, 3'd1); dat_a[6] = mk_dat(32'hF000_0000, 1, 1, 4'd0);
    lookup(32'h7000_0008, RD, 1'b0);
    expect_res("R5 user skip", HIT, 32'hF000_0008, 6'd6, 3'd1);
    lookup(32'h7000_0008, RD, 1'b1);
    expect_res("R5 priv uses entry", HIT, 32'hE000_0008, 6'd1, 3'd1);
    lookup(32'h7000_0008, WR, 1'b1);
    expect_res("R5 priv entry rights", FLT, 32'h0, 6'd1, 3'd1);
    lookup(32'h7000_0008, WR, 1'b0);
    expect_res("R5 user write skip", HIT, 32'hF000_0008, 6'd6, 3'd1);
  endtask

  task automatic t_zone_priv();
    clear_all();
    zpr = 32'h5955_5555;  // zone 2 -> 10
    tag_a[3] = mk_tag(32'h7100_0000, 3'd1); dat_a[3] = mk_dat(32'hE100_0000, 0, 0, 4'd2);
    lookup(32'h7100_0010, WR, 1'b1);
    expect_res("R6 priv write", HIT, 32'hE100_0010, 6'd3, 3'd1);
    lookup(32'h7100_0010, FE, 1'b1);
    expect_res("R6 priv fetch", HIT, 32'hE100_0010, 6'd3, 3'd1);
    lookup(32'h7100_0010, WR, 1'b0);
    expect_res("R6 user write", FLT, 32'h0, 6'd3, 3'd1);
    lookup(32'h7100_0010, RD, 1'b0);
    expect_res("R6 user read", HIT, 32'hE100_0010, 6'd3, 3'd1);
  endtask

  task automatic t_zone_all();
    clear_all();
    zpr = 32'h55D5_5555;  // zone 4 -> 11
    tag_a[8] = mk_tag(32'h7200_0000, 3'd1); dat_a[8] = mk_dat(32'hE200_0000, 0, 0, 4'd4);
    lookup(32'h7200_0020, FE, 1'b0);
    expect_res("R7 user fetch", HIT, 32'hE200_0020, 6'd8, 3'd1);
    lookup(32'h7200_0020, WR, 1'b0);
    expect_res("R7 user write", HIT, 32'hE200_0020, 6'd8, 3'd1);
  endtask

  task automatic t_zone_range();
    clear_all();
    zpr = 32'h0;
    tag_a[11] = mk_tag(32'h7300_0000, 3'd1); dat_a[11] = mk_dat(32'hE300_0000, 1, 1, 4'd9);
    tag_a[12] = mk_tag(32'h7400_0000, 3'd1); dat_a[12] = mk_dat(32'hE400_0000, 1, 1, 4'd8);
    lookup(32'h7300_0000, RD, 1'b0);
    expect_res("R8 zone above count", HIT, 32'hE300_0000, 6'd11, 3'd1);
    lookup(32'h7400_0000, RD, 1'b0);
    expect_res("R8 zone at count", MISS, 32'h0, 6'd0, 3'd0);
    expect_nz("R8 zones off no skip", HIT, 6'd12);
    zpr = 32'hFFFF_FFFF;
    tag_a[13] = mk_tag(32'h7500_0000, 3'd1); dat_a[13] = mk_dat(32'hE500_0000, 0, 0, 4'd1);
    lookup(32'h7500_0000, WR, 1'b0);
    expect_res("R8 zone on grants", HIT, 32'hE500_0000, 6'd13, 3'd1);
    expect_nz("R8 zones off entry rights", FLT, 6'd13);
    zpr = 32'h5555_5555;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_all();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_miss_empty();
    t_sizes();
    t_owner();
    t_prio();
    t_perm();
    t_zone_deny();
    t_zone_priv();
    t_zone_all();
    t_zone_range();
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule